// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one capture channel of a timer. It takes an asynchronous input, brings it into the clock domain through a short synchronizer chain, and passes it through a digital filter. The filter accepts a new input level only after that level has held for a programmable number of consecutive samples. The filtered signal feeds an edge detector. A selectable edge, optionally thinned by an edge divider, triggers a capture. A capture first records the free-running timer count supplied from outside in a shadow register. One cycle later it moves that value into the visible capture register and sets the capture flag.

Software sees a flag, an overcapture flag and an interrupt. It clears each flag with a one-cycle clear pulse. The edge choice, filter length and edge divider are held in working copies. These copies follow their inputs only while the channel is disabled, so reconfiguring a running channel cannot corrupt a measurement already under way. Typical uses are measuring pulse widths and periods of slow, noisy signals such as switch or sensor outputs.

Top module: `icap_channel`

## Requirements
- R1: After reset, captureValue is 0 and captureFlag, overFlag and irq are all 0.
- R2: filterCode values 0, 1, 2 and 3 require 1, 2, 4 and 8 consecutive synchronized samples at a new level before the filtered level changes. A pulse shorter than that count produces no capture.
- R3: edgeSel 2'b00 captures on rising filtered edges, 2'b01 on falling, 2'b11 on both, and 2'b10 behaves as rising. Edges of the unselected kind are ignored.
- R4: If rawIn changes before clock edge k and then holds, with a filter run length of N and an edge divider of 1, the shadow takes the timerCount present at edge k+2+N. captureValue and captureFlag update at edge k+3+N. captureValue changes at no other time.
- R5: While chanEnable is 0, no capture occurs. The edge-divider position returns to zero.
- R6: edgeSel, filterCode and edgeDiv are loaded into the working configuration only on clock edges where chanEnable is 0. Changes made while the channel is enabled have no effect until it is disabled.
- R7: edgeDiv values 0, 1, 2 and 3 make the channel capture on every 1st, 2nd, 4th and 8th selected edge. The first capture after enabling falls on that edge count.
- R8: A flagClear pulse clears captureFlag on the next edge. A capture committing on the same edge keeps the flag set.
- R9: A capture that commits while captureFlag is set, and is not being cleared in that cycle, sets overFlag. overClear clears it.
- R10: irq is high exactly when captureFlag and irqEnable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerCount | input | CNT_W | Free-running timer count to be captured |
| rawIn | input | 1 | Asynchronous input signal |
| chanEnable | input | 1 | Channel capture enable |
| edgeSel | input | 2 | Edge selection: 00 rising, 01 falling, 11 both, 10 rising |
| filterCode | input | 2 | Filter run length code: 1, 2, 4 or 8 samples |
| edgeDiv | input | 2 | Edge divider code: capture every 1, 2, 4 or 8 edges |
| irqEnable | input | 1 | Capture interrupt enable |
| flagClear | input | 1 | One-cycle pulse that clears captureFlag |
| overClear | input | 1 | One-cycle pulse that clears overFlag |
| captureValue | output | CNT_W | Last committed capture value |
| captureFlag | output | 1 | Capture occurred |
| overFlag | output | 1 | Capture occurred while the flag was still set |
| irq | output | 1 | Capture interrupt |

## Verification
Several properties are checked on every cycle. The filtered level never moves to a value that the synchronized input did not hold. Rising and falling pulses never coincide. The working configuration never changes while the channel was enabled. The capture register moves only on a commit strobe, and both flags rise only for their causes. Only the directed scenarios can show the exact capture latency and captured count for each filter length, and that short glitches are rejected. They also show edge-kind selection, divider counting, the clear-versus-set priority and the interrupt gating.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE     = 2'b00,
    EDGE_FALL     = 2'b01,
    EDGE_RISE_ALT = 2'b10,
    EDGE_BOTH     = 2'b11
  } edgeSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchShadow;  // take timerCount into the shadow this edge
    logic commit;       // move shadow into the visible register this edge
  } capStrobe_t;
endpackage

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic [CODE_W-1:0] filtCode,
  output logic              fltLevel,
  output logic              edgeRise,
  output logic              edgeFall
);
  localparam int MAX_RUN = 1 << ((1 << CODE_W) - 1);
  localparam int RUN_W   = $clog2(MAX_RUN);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncIn;
  logic [RUN_W:0]         runLen;
  logic [RUN_W-1:0]       runLast;
  logic [RUN_W-1:0]       runCnt;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign syncIn = syncQ[SYNC_STAGES-1];

  always_comb begin
    runLen  = (RUN_W+1)'(1) << filtCode;
    runLast = RUN_W'(runLen - (RUN_W+1)'(1));
  end

  // Run-length filter: level follows only after runLen disagreeing samples (R2)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fltLevel <= 1'b0;
      runCnt   <= '0;
      edgeRise <= 1'b0;
      edgeFall <= 1'b0;
    end else begin
      edgeRise <= 1'b0;
      edgeFall <= 1'b0;
      if (syncIn == fltLevel) begin
        runCnt <= '0;
      end else if (runCnt == runLast) begin
        fltLevel <= syncIn;
        runCnt   <= '0;
        edgeRise <= syncIn;
        edgeFall <= ~syncIn;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assert_filter_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fltLevel != $past(fltLevel)) |-> ($past(syncIn) == fltLevel));

  assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(edgeRise && edgeFall));
endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int CODE_W     = 2,
  parameter int DIV_CODE_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chanEnable,
  input  logic [1:0]            edgeSelIn,
  input  logic [CODE_W-1:0]     filterCodeIn,
  input  logic [DIV_CODE_W-1:0] edgeDivIn,
  input  logic                  edgeRise,
  input  logic                  edgeFall,
  output logic [CODE_W-1:0]     activeFilt,
  output capStrobe_t            stb
);
  localparam int MAX_DIV = 1 << ((1 << DIV_CODE_W) - 1);
  localparam int PRE_W   = $clog2(MAX_DIV);

  edgeSel_e              activeSel;
  logic [DIV_CODE_W-1:0] activeDiv;
  logic [PRE_W:0]        divLen;
  logic [PRE_W-1:0]      divLast;
  logic [PRE_W-1:0]      preCnt;
  logic                  selRise;
  logic                  selFall;
  logic                  qualify;
  logic                  latchNow;
  logic                  commitQ;

  // Working configuration loads only while disabled (R6)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSel  <= EDGE_RISE;
      activeFilt <= '0;
      activeDiv  <= '0;
    end else if (!chanEnable) begin
      activeSel  <= edgeSel_e'(edgeSelIn);
      activeFilt <= filterCodeIn;
      activeDiv  <= edgeDivIn;
    end
  end

  always_comb begin
    selRise  = (activeSel != EDGE_FALL);
    selFall  = (activeSel == EDGE_FALL) || (activeSel == EDGE_BOTH);
    qualify  = chanEnable && ((edgeRise && selRise) || (edgeFall && selFall));
    divLen   = (PRE_W+1)'(1) << activeDiv;
    divLast  = PRE_W'(divLen - (PRE_W+1)'(1));
    latchNow = qualify && (preCnt == divLast);
  end

  // Edge divider (R7), cleared while disabled (R5)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      commitQ <= 1'b0;
    end else begin
      commitQ <= latchNow;
      if (!chanEnable)      preCnt <= '0;
      else if (latchNow)    preCnt <= '0;
      else if (qualify)     preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    stb.latchShadow = latchNow;
    stb.commit      = commitQ;
  end

  assert_config_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(chanEnable) |-> ($stable(activeSel) && $stable(activeFilt) && $stable(activeDiv)));
endmodule

// File: rtl/icap_datapath.sv
module icap_datapath
  import icap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timerCount,
  input  capStrobe_t       stb,
  input  logic             irqEnable,
  input  logic             flagClear,
  input  logic             overClear,
  output logic [CNT_W-1:0] captureValue,
  output logic             captureFlag,
  output logic             overFlag,
  output logic             irq
);
  logic [CNT_W-1:0] shadowQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ      <= '0;
      captureValue <= '0;
      captureFlag  <= 1'b0;
      overFlag     <= 1'b0;
    end else begin
      if (stb.latchShadow) shadowQ <= timerCount;
      if (stb.commit) begin
        captureValue <= shadowQ;
        captureFlag  <= 1'b1;           // set wins over clear (R8)
        if (captureFlag && !flagClear) overFlag <= 1'b1;   // R9
        else if (overClear)            overFlag <= 1'b0;
      end else begin
        if (flagClear) captureFlag <= 1'b0;
        if (overClear) overFlag    <= 1'b0;
      end
    end
  end

  assign irq = captureFlag && irqEnable;  // R10

  assert_capture_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.commit) |-> $stable(captureValue));

  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(captureFlag) |-> $past(stb.commit));

  assert_over_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overFlag) |-> ($past(captureFlag) && $past(stb.commit)));
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timerCount,
  input  logic             rawIn,
  input  logic             chanEnable,
  input  logic [1:0]       edgeSel,
  input  logic [1:0]       filterCode,
  input  logic [1:0]       edgeDiv,
  input  logic             irqEnable,
  input  logic             flagClear,
  input  logic             overClear,
  output logic [CNT_W-1:0] captureValue,
  output logic             captureFlag,
  output logic             overFlag,
  output logic             irq
);
  logic       fltLevel;
  logic       edgeRise;
  logic       edgeFall;
  logic [1:0] activeFilt;
  capStrobe_t stb;

  icap_filter #(.SYNC_STAGES(SYNC_STAGES), .CODE_W(2)) filter_i (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .filtCode(activeFilt),
    .fltLevel(fltLevel), .edgeRise(edgeRise), .edgeFall(edgeFall)
  );

  icap_ctrl #(.CODE_W(2), .DIV_CODE_W(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .edgeSelIn(edgeSel),
    .filterCodeIn(filterCode), .edgeDivIn(edgeDiv), .edgeRise(edgeRise),
    .edgeFall(edgeFall), .activeFilt(activeFilt), .stb(stb)
  );

  icap_datapath #(.CNT_W(CNT_W)) datapath_i (
    .clk(clk), .rstN(rstN), .timerCount(timerCount), .stb(stb),
    .irqEnable(irqEnable), .flagClear(flagClear), .overClear(overClear),
    .captureValue(captureValue), .captureFlag(captureFlag),
    .overFlag(overFlag), .irq(irq)
  );

  logic unusedLevel;
  assign unusedLevel = fltLevel;
endmodule

// File: tb/icap_channel_tb.sv
module icap_channel_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timerCount;
  logic        rawIn = 1'b0;
  logic        chanEnable = 1'b0;
  logic [1:0]  edgeSel = 2'b00;
  logic [1:0]  filterCode = 2'b00;
  logic [1:0]  edgeDiv = 2'b00;
  logic        irqEnable = 1'b0;
  logic        flagClear = 1'b0;
  logic        overClear = 1'b0;
  logic [15:0] captureValue;
  logic        captureFlag;
  logic        overFlag;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;
  assign timerCount = cyc[15:0];

  icap_channel dut_i (
    .clk(clk), .rstN(rstN), .timerCount(timerCount), .rawIn(rawIn),
    .chanEnable(chanEnable), .edgeSel(edgeSel), .filterCode(filterCode),
    .edgeDiv(edgeDiv), .irqEnable(irqEnable), .flagClear(flagClear),
    .overClear(overClear), .captureValue(captureValue),
    .captureFlag(captureFlag), .overFlag(overFlag), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic v);
    rawIn = v;
    t0 = cyc;
  endtask

  task automatic configure(input logic [1:0] sel, input logic [1:0] fc, input logic [1:0] dv);
    chanEnable = 1'b0; edgeSel = sel; filterCode = fc; edgeDiv = dv;
    waitNeg(1);
    chanEnable = 1'b1;
    waitNeg(1);
  endtask

  task automatic clearAll();
    flagClear = 1'b1; overClear = 1'b1;
    waitNeg(1);
    flagClear = 1'b0; overClear = 1'b0;
  endtask

  task automatic test_reset();
    check(captureValue == 0, "R1 value", int'(captureValue), 0);
    check(captureFlag == 0,  "R1 flag", int'(captureFlag), 0);
    check(overFlag == 0,     "R1 over", int'(overFlag), 0);
    check(irq == 0,          "R1 irq", int'(irq), 0);
  endtask

  task automatic test_rise_basic();
    configure(2'b00, 2'b00, 2'b00);
    irqEnable = 1'b1;
    drive(1'b1);
    waitNeg(4);
    check(captureFlag == 0, "R4 flag before latency", int'(captureFlag), 0);
    waitNeg(1);
    check(captureFlag == 1, "R4 flag at latency", int'(captureFlag), 1);
    check(captureValue == 16'(t0 + 3), "R4 value N=1", int'(captureValue), (t0 + 3) & 16'hFFFF);
    check(irq == 1, "R10 irq high", int'(irq), 1);
    flagClear = 1'b1;
    waitNeg(1);
    flagClear = 1'b0;
    check(captureFlag == 0, "R8 clear", int'(captureFlag), 0);
    check(irq == 0, "R10 irq low", int'(irq), 0);
    drive(1'b0);
    waitNeg(8);
    check(captureFlag == 0, "R3 falling ignored", int'(captureFlag), 0);
    irqEnable = 1'b0;
  endtask

  task automatic test_filter();
    configure(2'b00, 2'b10, 2'b00);   // 4 samples
    rawIn = 1'b1; waitNeg(3); rawIn = 1'b0; waitNeg(10);
    check(captureFlag == 0, "R2 glitch rejected", int'(captureFlag), 0);
    drive(1'b1);
    waitNeg(7);
    check(captureFlag == 0, "R2 N=4 early", int'(captureFlag), 0);
    waitNeg(1);
    check(captureFlag == 1, "R2 N=4 flag", int'(captureFlag), 1);
    check(captureValue == 16'(t0 + 6), "R4 value N=4", int'(captureValue), (t0 + 6) & 16'hFFFF);
    check(irq == 0, "R10 irq gated", int'(irq), 0);
    clearAll();
  endtask

  task automatic test_fall_lock();
    configure(2'b01, 2'b11, 2'b00);   // falling, 8 samples
    drive(1'b0);
    waitNeg(11);
    check(captureFlag == 0, "R2 N=8 early", int'(captureFlag), 0);
    waitNeg(1);
    check(captureFlag == 1, "R3 falling flag", int'(captureFlag), 1);
    check(captureValue == 16'(t0 + 10), "R4 value N=8", int'(captureValue), (t0 + 10) & 16'hFFFF);
    clearAll();
    edgeSel = 2'b00; filterCode = 2'b00;   // changed while enabled
    drive(1'b1);
    waitNeg(14);
    check(captureFlag == 0, "R6 edge change ignored", int'(captureFlag), 0);
    drive(1'b0);
    waitNeg(11);
    check(captureFlag == 0, "R6 filter change ignored", int'(captureFlag), 0);
    waitNeg(1);
    check(captureValue == 16'(t0 + 10), "R6 old config value", int'(captureValue), (t0 + 10) & 16'hFFFF);
    clearAll();
  endtask

  task automatic test_both_over();
    configure(2'b11, 2'b00, 2'b00);
    drive(1'b1);
    waitNeg(8);
    check(captureFlag == 1, "R3 both rise", int'(captureFlag), 1);
    check(overFlag == 0, "R9 no over yet", int'(overFlag), 0);
    drive(1'b0);
    waitNeg(5);
    check(captureValue == 16'(t0 + 3), "R3 both fall value", int'(captureValue), (t0 + 3) & 16'hFFFF);
    check(overFlag == 1, "R9 over set", int'(overFlag), 1);
    overClear = 1'b1;
    waitNeg(1);
    overClear = 1'b0;
    check(overFlag == 0, "R9 over cleared", int'(overFlag), 0);
    clearAll();
  endtask

  task automatic test_divider();
    configure(2'b00, 2'b00, 2'b10);   // every 4th edge
    for (int i = 0; i < 4; i++) begin
      drive(1'b1);
      waitNeg(6);
      if (i < 3) check(captureFlag == 0, "R7 no capture before 4th", int'(captureFlag), 0);
      else check(captureValue == 16'(t0 + 3), "R7 4th edge value", int'(captureValue), (t0 + 3) & 16'hFFFF);
      rawIn = 1'b0;
      waitNeg(6);
    end
    check(captureFlag == 1, "R7 flag after 4th", int'(captureFlag), 1);
    clearAll();
  endtask

  task automatic test_disabled();
    configure(2'b11, 2'b00, 2'b00);
    chanEnable = 1'b0;
    rawIn = 1'b1; waitNeg(8);
    rawIn = 1'b0; waitNeg(8);
    check(captureFlag == 0, "R5 disabled no capture", int'(captureFlag), 0);
  endtask

  task automatic test_set_wins();
    configure(2'b00, 2'b00, 2'b00);
    drive(1'b1); waitNeg(8);
    rawIn = 1'b0; waitNeg(8);
    check(captureFlag == 1, "R8 flag set before", int'(captureFlag), 1);
    drive(1'b1);
    waitNeg(4);
    flagClear = 1'b1;
    waitNeg(1);
    flagClear = 1'b0;
    check(captureFlag == 1, "R8 set wins", int'(captureFlag), 1);
    check(overFlag == 0, "R9 no over when clearing", int'(overFlag), 0);
    check(captureValue == 16'(t0 + 3), "R8 value", int'(captureValue), (t0 + 3) & 16'hFFFF);
  endtask

  initial begin
    waitNeg(3);
    test_reset();
    rstN = 1'b1;
    waitNeg(2);
    test_reset();
    test_rise_basic();
    test_filter();
    test_fall_lock();
    test_both_over();
    test_divider();
    test_disabled();
    test_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule